// File: doc/BRIEF.md
# Shift and Rotate Execution Unit

This block is the shift and rotate execution stage of a 32-bit RISC core. Each cycle it may accept one 16-bit instruction word together with the two register operands (the destination value and the source value) and the current T flag. It decodes sixteen shift encodings and returns the new destination value, the new T value and their write enables. It also returns an illegal-opcode flag. All of these come from registers and appear exactly one cycle after the accepted word.

The forms are as follows. Single-bit rotates and rotates through T move the bit that leaves the word into T. Single-bit arithmetic and logical shifts also move the ejected bit into T. Fixed shifts by 2, 8 and 16 fill with zeros and leave T alone. The two dynamic shifts read the sign of the source operand to pick the direction and read its low five bits to pick the amount. The register file, fetch and hazard logic sit outside this block.

Top module: `shift_rot_exec`

## Requirements
- R1: A word is legal only when bits 15:12 equal 4'b0100 and its low byte is one of the sixteen forms listed in R2 to R7. A valid but illegal word sets out_illegal for one cycle, keeps both write enables low, gives out_res = 0 and gives out_t = in_t.
- R2: Low byte 8'h04 rotates left by one and low byte 8'h05 rotates right by one. In both, the bit that wraps around is also written to T.
- R3: Low byte 8'h24 rotates left through T: the old T enters bit 0 and the old bit 31 becomes T. Low byte 8'h25 rotates right through T: the old T enters bit 31 and the old bit 0 becomes T.
- R4: Low bytes 8'h00 and 8'h20 shift left by one with a zero fill, and the old bit 31 goes to T. Low byte 8'h21 shifts right by one and keeps bit 31, and the old bit 0 goes to T. Low byte 8'h01 shifts right by one with a zero fill, and the old bit 0 goes to T.
- R5: Low bytes 8'h08/8'h09, 8'h18/8'h19 and 8'h28/8'h29 shift left/right by 2, 8 and 16 with a zero fill. They write the result, keep out_t_we low and give out_t = in_t.
- R6: Low nibble 4'hC (bits 7:4 free) is the dynamic arithmetic shift. When in_rm is zero or positive, the operand shifts left by the amount. When in_rm is negative, it shifts right by the magnitude and fills with bit 31. T is not written.
- R7: Low nibble 4'hD (bits 7:4 free) is the dynamic logical shift. It shifts left in the same way as R6, but a negative in_rm gives a zero-fill right shift. T is not written.
- R8: The dynamic amount uses only in_rm[4:0]. A negative in_rm whose low five bits are zero means a right shift by 32, which gives all sign bits (R6) or all zeros (R7).
- R9: The outputs appear exactly one cycle after in_valid. A cycle without in_valid gives zero on out_res, out_res_we, out_t, out_t_we and out_illegal in the next cycle.
- R10: While rst is high, all outputs are zero on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word present this cycle |
| in_insn | input | 16 | Instruction word |
| in_rn | input | 32 | Destination operand value |
| in_rm | input | 32 | Source operand value (dynamic forms) |
| in_t | input | 1 | Current T flag |
| out_res | output | 32 | New destination value |
| out_res_we | output | 1 | Destination write enable |
| out_t | output | 1 | New T value |
| out_t_we | output | 1 | T write enable |
| out_illegal | output | 1 | Unknown encoding seen |

## Verification
For the single-bit forms, the result write and the T write happen in the same cycle. The flag must be the exact bit that left the operand, and the destination write must not be delayed or dropped. The bench provokes this by sending rotate and single-bit shift words back to back, with operand edge bits chosen so that the old and new T differ. It then judges out_res, out_res_we, out_t and out_t_we together at one sample point. The fixed and dynamic forms are mixed into the same stream with in_t set, so that a stray T write cannot go unnoticed.

// File: rtl/shift_rot_pkg.sv
package shift_rot_pkg;
  typedef enum logic [4:0] {
    OP_ILL,
    OP_ROL1, OP_ROR1, OP_RCL1, OP_RCR1,
    OP_SHL1, OP_SAR1, OP_SHR1,
    OP_SHL2, OP_SHR2, OP_SHL8, OP_SHR8, OP_SHL16, OP_SHR16,
    OP_DYN_A, OP_DYN_L
  } shop_e;

  localparam logic [3:0] GROUP_CODE = 4'b0100;
endpackage

// File: rtl/shift_rot_decode.sv
module shift_rot_decode
  import shift_rot_pkg::*;
#(
  parameter int INSN_W = 16
) (
  input  logic [INSN_W-1:0] insn,
  output shop_e             op
);
  logic [7:0] lo;
  assign lo = insn[7:0];

  always_comb begin
    op = OP_ILL;
    if (insn[INSN_W-1 -: 4] == GROUP_CODE) begin
      if (lo[3:0] == 4'hC) op = OP_DYN_A;
      else if (lo[3:0] == 4'hD) op = OP_DYN_L;
      else begin
        case (lo)
          8'h04: op = OP_ROL1;
          8'h05: op = OP_ROR1;
          8'h24: op = OP_RCL1;
          8'h25: op = OP_RCR1;
          8'h00, 8'h20: op = OP_SHL1;
          8'h21: op = OP_SAR1;
          8'h01: op = OP_SHR1;
          8'h08: op = OP_SHL2;
          8'h09: op = OP_SHR2;
          8'h18: op = OP_SHL8;
          8'h19: op = OP_SHR8;
          8'h28: op = OP_SHL16;
          8'h29: op = OP_SHR16;
          default: op = OP_ILL;
        endcase
      end
    end
  end
endmodule

// File: rtl/shift_rot_core.sv
module shift_rot_core
  import shift_rot_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  shop_e             op,
  input  logic [DATA_W-1:0] rn,
  input  logic [DATA_W-1:0] rm,
  input  logic              t_in,
  output logic [DATA_W-1:0] res,
  output logic              res_we,
  output logic              t_out,
  output logic              t_we
);
  localparam int AMT_W = $clog2(DATA_W);
  localparam int MAG_W = AMT_W + 1;

  logic [AMT_W-1:0] amt;
  logic [MAG_W-1:0] mag;
  logic             neg;
  logic [DATA_W-1:0] dyn_left, dyn_sra, dyn_srl;

  assign amt = rm[AMT_W-1:0];
  assign neg = rm[DATA_W-1];
  // magnitude of a negative amount; low bits zero means a full-width shift
  assign mag = {1'b0, ~amt} + MAG_W'(1);
  assign dyn_left = rn << amt;
  assign dyn_sra  = DATA_W'($signed(rn) >>> mag);
  assign dyn_srl  = rn >> mag;

  always_comb begin
    res    = '0;
    res_we = 1'b1;
    t_out  = t_in;
    t_we   = 1'b0;
    case (op)
      OP_ROL1: begin res = {rn[DATA_W-2:0], rn[DATA_W-1]}; t_out = rn[DATA_W-1]; t_we = 1'b1; end
      OP_ROR1: begin res = {rn[0], rn[DATA_W-1:1]};        t_out = rn[0];        t_we = 1'b1; end
      OP_RCL1: begin res = {rn[DATA_W-2:0], t_in};         t_out = rn[DATA_W-1]; t_we = 1'b1; end
      OP_RCR1: begin res = {t_in, rn[DATA_W-1:1]};         t_out = rn[0];        t_we = 1'b1; end
      OP_SHL1: begin res = {rn[DATA_W-2:0], 1'b0};         t_out = rn[DATA_W-1]; t_we = 1'b1; end
      OP_SAR1: begin res = {rn[DATA_W-1], rn[DATA_W-1:1]}; t_out = rn[0];        t_we = 1'b1; end
      OP_SHR1: begin res = {1'b0, rn[DATA_W-1:1]};         t_out = rn[0];        t_we = 1'b1; end
      OP_SHL2:  res = rn << 2;
      OP_SHR2:  res = rn >> 2;
      OP_SHL8:  res = rn << 8;
      OP_SHR8:  res = rn >> 8;
      OP_SHL16: res = rn << 16;
      OP_SHR16: res = rn >> 16;
      OP_DYN_A: res = neg ? dyn_sra : dyn_left;
      OP_DYN_L: res = neg ? dyn_srl : dyn_left;
      default:  res_we = 1'b0;
    endcase
  end
endmodule

// File: rtl/shift_rot_exec.sv
module shift_rot_exec
  import shift_rot_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int INSN_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] in_insn,
  input  logic [DATA_W-1:0] in_rn,
  input  logic [DATA_W-1:0] in_rm,
  input  logic              in_t,
  output logic [DATA_W-1:0] out_res,
  output logic              out_res_we,
  output logic              out_t,
  output logic              out_t_we,
  output logic              out_illegal
);
  shop_e             op;
  logic [DATA_W-1:0] c_res;
  logic              c_res_we, c_t, c_t_we;

  shift_rot_decode #(.INSN_W(INSN_W)) u_dec (
    .insn (in_insn),
    .op   (op)
  );

  shift_rot_core #(.DATA_W(DATA_W)) u_core (
    .op     (op),
    .rn     (in_rn),
    .rm     (in_rm),
    .t_in   (in_t),
    .res    (c_res),
    .res_we (c_res_we),
    .t_out  (c_t),
    .t_we   (c_t_we)
  );

  always_ff @(posedge clk) begin
    if (rst || !in_valid) begin
      out_res     <= '0;
      out_res_we  <= 1'b0;
      out_t       <= 1'b0;
      out_t_we    <= 1'b0;
      out_illegal <= 1'b0;
    end else begin
      out_res     <= c_res;
      out_res_we  <= c_res_we;
      out_t       <= c_t;
      out_t_we    <= c_t_we;
      out_illegal <= (op == OP_ILL);
    end
  end
endmodule

// File: rtl/shift_rot_exec_chk.sv
module shift_rot_exec_chk #(
  parameter int DATA_W = 32,
  parameter int INSN_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [INSN_W-1:0] in_insn,
  input logic [DATA_W-1:0] out_res,
  input logic              out_res_we,
  input logic              out_t,
  input logic              out_t_we,
  input logic              out_illegal
);
  logic grp, fixed_multi, dyn_form, rotl, rotr;
  assign grp         = in_insn[INSN_W-1 -: 4] == 4'b0100;
  assign fixed_multi = grp && (in_insn[3:1] == 3'b100) &&
                       (in_insn[7:4] == 4'h0 || in_insn[7:4] == 4'h1 || in_insn[7:4] == 4'h2);
  assign dyn_form    = grp && (in_insn[3:0] == 4'hC || in_insn[3:0] == 4'hD);
  assign rotl        = grp && in_insn[7:0] == 8'h04;
  assign rotr        = grp && in_insn[7:0] == 8'h05;

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_res_we && !out_t_we && !out_illegal);
  p_one_outcome_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_res_we ^ out_illegal));
  p_illegal_no_write_r1: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> !out_res_we && !out_t_we);
  p_fixed_keeps_t_r5: assert property (@(posedge clk) disable iff (rst)
    in_valid && fixed_multi |=> out_res_we && !out_t_we);
  p_dyn_keeps_t_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid && dyn_form |=> out_res_we && !out_t_we);
  p_rotl_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid && rotl |=> out_t_we && out_t == out_res[0]);
  p_rotr_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid && rotr |=> out_t_we && out_t == out_res[DATA_W-1]);
endmodule

bind shift_rot_exec shift_rot_exec_chk #(.DATA_W(DATA_W), .INSN_W(INSN_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn),
  .out_res(out_res), .out_res_we(out_res_we), .out_t(out_t),
  .out_t_we(out_t_we), .out_illegal(out_illegal)
);

// File: tb/sim_shift_rot_exec.sv
`timescale 1ns/1ps
module sim_shift_rot_exec;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_insn = '0;
  logic [31:0] in_rn = '0, in_rm = '0;
  logic        in_t = 1'b0;
  logic [31:0] out_res;
  logic        out_res_we, out_t, out_t_we, out_illegal;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  shift_rot_exec u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn),
    .in_rn(in_rn), .in_rm(in_rm), .in_t(in_t),
    .out_res(out_res), .out_res_we(out_res_we), .out_t(out_t),
    .out_t_we(out_t_we), .out_illegal(out_illegal)
  );

  // insn, rn, rm, t, res, res_we, t_out, t_we, illegal
  localparam int NV = 24;
  localparam logic [116:0] VEC [NV] = '{
    {16'h4104, 32'h80000001, 32'h0, 1'b0, 32'h00000003, 1'b1, 1'b1, 1'b1, 1'b0},
    {16'h4205, 32'h80000002, 32'h0, 1'b1, 32'h40000001, 1'b1, 1'b0, 1'b1, 1'b0},
    {16'h4324, 32'h80000000, 32'h0, 1'b1, 32'h00000001, 1'b1, 1'b1, 1'b1, 1'b0},
    {16'h4425, 32'h00000001, 32'h0, 1'b0, 32'h00000000, 1'b1, 1'b1, 1'b1, 1'b0},
    {16'h4520, 32'hC0000000, 32'h0, 1'b0, 32'h80000000, 1'b1, 1'b1, 1'b1, 1'b0},
    {16'h4600, 32'h40000000, 32'h0, 1'b1, 32'h80000000, 1'b1, 1'b0, 1'b1, 1'b0},
    {16'h4721, 32'h80000003, 32'h0, 1'b0, 32'hC0000001, 1'b1, 1'b1, 1'b1, 1'b0},
    {16'h4801, 32'h80000002, 32'h0, 1'b1, 32'h40000001, 1'b1, 1'b0, 1'b1, 1'b0},
    {16'h4908, 32'h12345678, 32'h0, 1'b1, 32'h48D159E0, 1'b1, 1'b1, 1'b0, 1'b0},
    {16'h4A09, 32'h12345678, 32'h0, 1'b1, 32'h048D159E, 1'b1, 1'b1, 1'b0, 1'b0},
    {16'h4B18, 32'h12345678, 32'h0, 1'b0, 32'h34567800, 1'b1, 1'b0, 1'b0, 1'b0},
    {16'h4C19, 32'h12345678, 32'h0, 1'b1, 32'h00123456, 1'b1, 1'b1, 1'b0, 1'b0},
    {16'h4D28, 32'h12345678, 32'h0, 1'b0, 32'h56780000, 1'b1, 1'b0, 1'b0, 1'b0},
    {16'h4E29, 32'h12345678, 32'h0, 1'b1, 32'h00001234, 1'b1, 1'b1, 1'b0, 1'b0},
    {16'h412C, 32'h00000003, 32'h00000004, 1'b1, 32'h00000030, 1'b1, 1'b1, 1'b0, 1'b0},
    {16'h412C, 32'h80000010, 32'hFFFFFFFE, 1'b0, 32'hE0000004, 1'b1, 1'b0, 1'b0, 1'b0},
    {16'h412D, 32'h80000010, 32'hFFFFFFFE, 1'b1, 32'h20000004, 1'b1, 1'b1, 1'b0, 1'b0},
    {16'h41FC, 32'h80000000, 32'hFFFFFFE0, 1'b0, 32'hFFFFFFFF, 1'b1, 1'b0, 1'b0, 1'b0},
    {16'h419D, 32'hFFFFFFFF, 32'hFFFFFFE0, 1'b1, 32'h00000000, 1'b1, 1'b1, 1'b0, 1'b0},
    {16'h412D, 32'h00000001, 32'h00000021, 1'b0, 32'h00000002, 1'b1, 1'b0, 1'b0, 1'b0},
    {16'h412C, 32'h0000ABCD, 32'h7FFFFFE0, 1'b1, 32'h0000ABCD, 1'b1, 1'b1, 1'b0, 1'b0},
    {16'h5104, 32'h80000001, 32'h0, 1'b1, 32'h00000000, 1'b0, 1'b1, 1'b0, 1'b1},
    {16'h4110, 32'h80000001, 32'h0, 1'b0, 32'h00000000, 1'b0, 1'b0, 1'b0, 1'b1},
    {16'h4102, 32'h80000001, 32'h0, 1'b1, 32'h00000000, 1'b0, 1'b1, 1'b0, 1'b1}
  };

  function automatic string req_of(input logic [15:0] w);
    if (w[15:12] != 4'b0100) return "R1";
    if (w[3:0] == 4'hC) return "R6/R8";
    if (w[3:0] == 4'hD) return "R7/R8";
    case (w[7:0])
      8'h04, 8'h05: return "R2";
      8'h24, 8'h25: return "R3";
      8'h00, 8'h20, 8'h21, 8'h01: return "R4";
      8'h08, 8'h09, 8'h18, 8'h19, 8'h28, 8'h29: return "R5";
      default: return "R1";
    endcase
  endfunction

  task automatic check_out(input string req, input logic [31:0] res, input logic rwe,
                           input logic tv, input logic twe, input logic ill);
    checks++;
    if (out_res !== res || out_res_we !== rwe || out_t !== tv ||
        out_t_we !== twe || out_illegal !== ill) begin
      errors++;
      $display("FAIL %s: got res=%h rwe=%b t=%b twe=%b ill=%b, expected res=%h rwe=%b t=%b twe=%b ill=%b",
               req, out_res, out_res_we, out_t, out_t_we, out_illegal, res, rwe, tv, twe, ill);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    check_out("R10 reset", 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);

    // vector table, issued back to back (R9: one cycle latency)
    for (int i = 0; i < NV; i++) begin
      in_valid = 1'b1;
      in_insn  = VEC[i][116:101];
      in_rn    = VEC[i][100:69];
      in_rm    = VEC[i][68:37];
      in_t     = VEC[i][36];
      @(negedge clk);
      check_out(req_of(VEC[i][116:101]), VEC[i][35:4], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R9: legal word without valid produces nothing
    in_valid = 1'b0;
    in_insn  = 16'h4104;
    in_rn    = 32'h80000001;
    in_t     = 1'b1;
    @(negedge clk);
    check_out("R9 idle", 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R9: output after exactly one cycle, then gone
    in_valid = 1'b1;
    in_insn  = 16'h4E29;
    in_rn    = 32'hFFFF0000;
    @(negedge clk);
    in_valid = 1'b0;
    check_out("R9 latency", 32'h0000FFFF, 1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    check_out("R9 drop", 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R8: negative amount -1 shifts right by one (arith keeps sign)
    in_valid = 1'b1;
    in_insn  = 16'h4A3C;
    in_rn    = 32'h80000000;
    in_rm    = 32'hFFFFFFFF;
    in_t     = 1'b0;
    @(negedge clk);
    check_out("R8 minus one", 32'hC0000000, 1'b1, 1'b0, 1'b0, 1'b0);

    // R10: reset overrides a valid word
    rst     = 1'b1;
    in_insn = 16'h4104;
    in_rn   = 32'h80000001;
    @(negedge clk);
    check_out("R10 reset with valid", 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    rst      = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule